// File: doc/BRIEF.md
# Fine-Grained Write Trap Checker

This block decides, for each privileged system-register write, whether that write must be diverted to the hypervisor level. It holds a 64-bit trap-control register. Each defined bit guards one register and is active-low: a cleared bit means writes to that register are trapped, and a set bit means this mechanism lets them through. Only two bits are defined. Bit 0 guards the fault-address register. Bit 2 guards the mask register. Every other bit reads as zero and cannot be written.

For each write request, the block looks at the target-register identifier, the write form (single or paired), the current exception level, the execution state, and the hypervisor flags. A trap is raised only under all of these conditions:
- the write comes from level 1 in the 64-bit state;
- the hypervisor level exists and is enabled;
- no higher-priority exception is already pending;
- the guard bit for the target register is clear.

A raised trap names level 2 as the target and carries syndrome class 0x18. The decision is combinational from the registered control value, so it is valid in the same cycle as the request strobe. Control-register updates travel from the control logic to the datapath register through a small strobe struct.

Top module: `fgwt_top`

## Requirements
- R1: After reset the control register reads as 0. Because the guard bits are active-low, a level-1 64-bit single-form write to the fault-address register (identifier 0) is then trapped while the hypervisor level exists and is enabled.
- R2: A control write (`ctlWrEn` high while `hypPresent` is high) stores only bits 0 and 2. All other bits read back as 0, and the new value is visible from the cycle after the write.
- R3: While `hypPresent` is low, `ctlRdData` reads 0, control writes are ignored, and `trapReq` stays low for every request.
- R4: A single-form write (`reqPaired`=0) to identifier 0 is trapped when bit 0 is 0, and is not trapped when bit 0 is 1.
- R5: A paired-form write (`reqPaired`=1) to identifier 0 is never trapped, whatever the value of bit 0.
- R6: Writes to the mask register (identifier 1) are trapped in both the single and paired forms when bit 2 is 0, and in neither form when bit 2 is 1.
- R7: A trap is raised only when `curLevel` equals 1 and `isWide` is 1. Requests at levels 0, 2 and 3, or with `isWide`=0, are never trapped.
- R8: No trap is raised while `hypEnabled` is low.
- R9: No trap is raised while `priorPending` is high.
- R10: While `trapReq` is high, `trapLevel` is 2 and `trapClass` is 0x18. While `trapReq` is low, both are 0.
- R11: The decision is combinational and valid in the cycle `reqValid` is high. It uses the control value held before any control write issued in that same cycle. With `reqValid` low, or for any identifier other than 0 and 1, no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control-register write strobe |
| ctlWrData | input | 64 | Control-register write value |
| ctlRdData | output | 64 | Control-register read value |
| reqValid | input | 1 | Guarded-write request strobe |
| reqId | input | 4 | Target register identifier (0 fault-address, 1 mask) |
| reqPaired | input | 1 | 1 for the paired-register write form |
| curLevel | input | 2 | Current exception level, 0 to 3 |
| isWide | input | 1 | 1 when executing in the 64-bit state |
| hypPresent | input | 1 | Hypervisor level implemented |
| hypEnabled | input | 1 | Hypervisor level enabled in the current security state |
| priorPending | input | 1 | A higher-priority exception is already pending |
| trapReq | output | 1 | Divert the write to the hypervisor level |
| trapLevel | output | 2 | Target level of the trap (2), else 0 |
| trapClass | output | 6 | Syndrome class of the trap (0x18), else 0 |

## Verification
A control-register update and a guarded-write decision can land in the same cycle, and that decision must use the old control value. The bench provokes this by clearing the register and then issuing a write of 0x5 together with a single-form fault-address request. The scoreboard expects a trap in that cycle, computed from the pre-write model. It expects no trap for the same request in the following cycle, and the read value 0x5 must appear only in that following cycle.

// File: rtl/fgwt_pkg.sv
package fgwt_pkg;
  localparam logic [1:0] LVL_EL1    = 2'd1;
  localparam logic [1:0] LVL_EL2    = 2'd2;
  localparam logic [5:0] TRAP_CLASS = 6'h18;

  typedef struct packed {
    logic load;  // capture write data into the control register
    logic hide;  // hypervisor level absent: present zero on read
  } ctlStrobes_t;
endpackage

// File: rtl/fgwt_datapath.sv
module fgwt_datapath
  import fgwt_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int FAULT_BIT = 0,
  parameter int MASK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              faultAllow,
  output logic              maskAllow
);
  localparam logic [DATA_W-1:0] DEF_MASK =
    (DATA_W'(1) << FAULT_BIT) | (DATA_W'(1) << MASK_BIT);

  logic [DATA_W-1:0] regQ;

  always_ff @(posedge clk) begin
    if (!rstN)             regQ <= '0;
    else if (strobes.load) regQ <= wrData & DEF_MASK;
  end

  assign rdData     = strobes.hide ? '0 : regQ;
  assign faultAllow = regQ[FAULT_BIT];
  assign maskAllow  = regQ[MASK_BIT];

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.load) |-> $stable(regQ)); // R3
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~DEF_MASK) == '0); // R2
endmodule

// File: rtl/fgwt_ctrl.sv
module fgwt_ctrl
  import fgwt_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int FAULT_ID = 0,
  parameter int MASK_ID  = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWrEn,
  input  logic            reqValid,
  input  logic [ID_W-1:0] reqId,
  input  logic            reqPaired,
  input  logic [1:0]      curLevel,
  input  logic            isWide,
  input  logic            hypPresent,
  input  logic            hypEnabled,
  input  logic            priorPending,
  input  logic            faultAllow,
  input  logic            maskAllow,
  output ctlStrobes_t     strobes,
  output logic            trapReq,
  output logic [1:0]      trapLevel,
  output logic [5:0]      trapClass
);
  logic levelOk, hypOk, faultHit, maskHit;

  always_comb begin
    strobes.load = ctlWrEn && hypPresent;
    strobes.hide = !hypPresent;
  end

  assign levelOk  = reqValid && (curLevel == LVL_EL1) && isWide;
  assign hypOk    = hypPresent && hypEnabled;
  assign faultHit = (reqId == ID_W'(FAULT_ID)) && !reqPaired && !faultAllow;
  assign maskHit  = (reqId == ID_W'(MASK_ID)) && !maskAllow;
  assign trapReq  = levelOk && hypOk && (faultHit || maskHit) && !priorPending;
  assign trapLevel = trapReq ? LVL_EL2 : 2'd0;
  assign trapClass = trapReq ? TRAP_CLASS : 6'd0;

  AST_PRIOR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    priorPending |-> !trapReq); // R9
  AST_NO_HYP_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    !hypPresent |-> !trapReq); // R3
  AST_PAIRED_FAULT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (reqId == ID_W'(FAULT_ID) && reqPaired) |-> !trapReq); // R5
  AST_LEVEL_ONLY_EL1: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (curLevel == LVL_EL1 && isWide && hypEnabled)); // R7
  AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (trapLevel == LVL_EL2 && trapClass == TRAP_CLASS)); // R10
endmodule

// File: rtl/fgwt_top.sv
module fgwt_top
  import fgwt_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ID_W      = 4,
  parameter int FAULT_ID  = 0,
  parameter int MASK_ID   = 1,
  parameter int FAULT_BIT = 0,
  parameter int MASK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  output logic [DATA_W-1:0] ctlRdData,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqPaired,
  input  logic [1:0]        curLevel,
  input  logic              isWide,
  input  logic              hypPresent,
  input  logic              hypEnabled,
  input  logic              priorPending,
  output logic              trapReq,
  output logic [1:0]        trapLevel,
  output logic [5:0]        trapClass
);
  ctlStrobes_t strobes;
  logic faultAllow, maskAllow;

  fgwt_ctrl #(.ID_W(ID_W), .FAULT_ID(FAULT_ID), .MASK_ID(MASK_ID)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .reqValid(reqValid),
    .reqId(reqId), .reqPaired(reqPaired), .curLevel(curLevel), .isWide(isWide),
    .hypPresent(hypPresent), .hypEnabled(hypEnabled), .priorPending(priorPending),
    .faultAllow(faultAllow), .maskAllow(maskAllow), .strobes(strobes),
    .trapReq(trapReq), .trapLevel(trapLevel), .trapClass(trapClass)
  );

  fgwt_datapath #(.DATA_W(DATA_W), .FAULT_BIT(FAULT_BIT), .MASK_BIT(MASK_BIT)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(ctlWrData),
    .rdData(ctlRdData), .faultAllow(faultAllow), .maskAllow(maskAllow)
  );
endmodule

// File: tb/test_fgwt_top.sv
`timescale 1ns/1ps
module test_fgwt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [63:0] ctlWrData = '0;
  logic [63:0] ctlRdData;
  logic        reqValid = 1'b0;
  logic [3:0]  reqId = '0;
  logic        reqPaired = 1'b0;
  logic [1:0]  curLevel = 2'd1;
  logic        isWide = 1'b1;
  logic        hypPresent = 1'b1;
  logic        hypEnabled = 1'b1;
  logic        priorPending = 1'b0;
  logic        trapReq;
  logic [1:0]  trapLevel;
  logic [5:0]  trapClass;

  always #4 clk = ~clk; // 125 MHz

  fgwt_top i_fgwt_top (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .reqValid(reqValid), .reqId(reqId),
    .reqPaired(reqPaired), .curLevel(curLevel), .isWide(isWide),
    .hypPresent(hypPresent), .hypEnabled(hypEnabled), .priorPending(priorPending),
    .trapReq(trapReq), .trapLevel(trapLevel), .trapClass(trapClass)
  );

  typedef struct {
    logic        trap;
    logic [1:0]  lvl;
    logic [5:0]  cls;
    logic [63:0] rd;
    string       tag;
  } item_t;

  item_t       sbQ[$];
  logic [63:0] modelReg = '0;
  int          nTests = 0;
  int          nFail  = 0;
  bit          done   = 0;

  // drive one cycle of stimulus, push the expected result, then update the model
  task automatic drive(input logic wr, input logic [63:0] wd, input logic v,
                       input logic [3:0] id, input logic pr, input logic [1:0] lv,
                       input logic wide, input logic hp, input logic he,
                       input logic pp, input string tag);
    item_t e;
    logic guard;
    @(posedge clk); #1;
    ctlWrEn = wr; ctlWrData = wd; reqValid = v; reqId = id; reqPaired = pr;
    curLevel = lv; isWide = wide; hypPresent = hp; hypEnabled = he; priorPending = pp;
    guard = (id == 4'd0 && !pr && !modelReg[0]) || (id == 4'd1 && !modelReg[2]);
    e.trap = v && lv == 2'd1 && wide && hp && he && !pp && guard;
    e.lvl  = e.trap ? 2'd2 : 2'd0;
    e.cls  = e.trap ? 6'h18 : 6'd0;
    e.rd   = hp ? modelReg : 64'd0;
    e.tag  = tag;
    sbQ.push_back(e);
    if (wr && hp) modelReg = wd & 64'h5;
  endtask

  task automatic req(input logic [3:0] id, input logic pr, input string tag);
    drive(1'b0, '0, 1'b1, id, pr, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, tag);
  endtask

  task automatic wrCtl(input logic [63:0] wd, input string tag);
    drive(1'b1, wd, 1'b0, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, tag);
  endtask

  // monitor: compare in the middle of the cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        item_t e;
        e = sbQ.pop_front();
        nTests++;
        if (trapReq !== e.trap || trapLevel !== e.lvl || trapClass !== e.cls ||
            ctlRdData !== e.rd) begin
          nFail++;
          $display("FAIL %s: got trap=%0b lvl=%0d cls=%h rd=%h, exp trap=%0b lvl=%0d cls=%h rd=%h",
                   e.tag, trapReq, trapLevel, trapClass, ctlRdData,
                   e.trap, e.lvl, e.cls, e.rd);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    req(4'd0, 1'b0, "R1 reset value traps fault single");
    req(4'd1, 1'b0, "R1 reset value traps mask");
    wrCtl(64'hFFFF_FFFF_FFFF_FFFF, "R2 write all ones");
    req(4'd0, 1'b0, "R2 reserved bits read zero / R4 bit0 set no trap");
    req(4'd1, 1'b0, "R6 mask bit set single no trap");
    req(4'd1, 1'b1, "R6 mask bit set paired no trap");
    wrCtl(64'h0000_0000_0000_0004, "R2 write mask bit only");
    req(4'd0, 1'b0, "R4 bit0 clear traps single R10");
    req(4'd0, 1'b1, "R5 paired fault never trapped");
    req(4'd1, 1'b0, "R6 mask bit set no trap");
    wrCtl(64'hA5A5_0000_0000_0001, "R2 write fault bit only");
    req(4'd1, 1'b0, "R6 mask bit clear single trap");
    req(4'd1, 1'b1, "R6 mask bit clear paired trap");
    req(4'd0, 1'b0, "R4 bit0 set no trap");
    wrCtl(64'h0, "R2 clear all");
    req(4'd0, 1'b1, "R5 paired fault with bit0 clear");
    for (int l = 0; l < 4; l++)
      drive(1'b0, '0, 1'b1, 4'd0, 1'b0, 2'(l), 1'b1, 1'b1, 1'b1, 1'b0, "R7 level sweep");
    drive(1'b0, '0, 1'b1, 4'd1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 narrow state no trap");
    drive(1'b0, '0, 1'b1, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 hyp disabled no trap");
    drive(1'b0, '0, 1'b1, 4'd1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 prior pending wins");
    drive(1'b0, '0, 1'b1, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 prior pending fault");
    for (int id = 2; id < 16; id += 3)
      req(4'(id), 1'b0, "R11 other identifier no trap");
    drive(1'b0, '0, 1'b0, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R11 no strobe no trap");
    drive(1'b0, '0, 1'b1, 4'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R3 absent hyp no trap");
    drive(1'b1, 64'h5, 1'b1, 4'd1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R3 write while absent");
    req(4'd0, 1'b0, "R3 ignored write keeps zero, traps");
    drive(1'b1, 64'h5, 1'b1, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R11 same-cycle write uses old value");
    req(4'd0, 1'b0, "R11 next cycle sees new value");
    req(4'd1, 1'b1, "R10 no trap fields zero");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule